// File: doc/BRIEF.md
# DisplayPort Stream Event Classifier

This block watches the decoded symbol stream of a DisplayPort main link. The symbols come from one, two or four lanes and are already decoded, aligned and descrambled. Each lane supplies one byte per clock and a flag that marks a control (K) symbol. Every clock is one state. For each state the block produces an 8-bit event code, registered with one cycle of latency. The code tells whether the state belongs to active video or to blanking, which field or blanking kind is current, and what kind of symbol or packet the state carries. The two low bits of the code carry error flags.

The block follows the stream through blanking start, the VBID/MVID/MAUD attribute states, dummy fill, secondary-data packets and active video with its fill runs. It checks that all active lanes agree on control symbols and on the attribute fields. It checks the attribute fields against the no-video and audio-mute bits. It also watches for scrambler resets that stop arriving. A data-error output and a one-clock packet-recognized pulse go with the code.

Lane 0 is the reference lane that the block classifies. The other active lanes are used only for the agreement checks and for the scrambler-reset watchdog.

Top module: `dp_event_classifier`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are `event_code`=0, `data_error`=0 and `pkt_seen`=0. After reset the block is in blanking, with the vertical flag and the field both 0.
- R2: Code bit 7 is 1 for active-video states and 0 for blanking states. In video, bit 6 is the field taken from VBID bit 1. In blanking, bit 6 is the vertical-blanking flag taken from VBID bit 0. On the VBID state itself, bit 6 already shows the new VBID bit 0.
- R3: Control symbols are identified on lane 0: BS=K 0xBC, SR=K 0x1C, BE=K 0xFB, SS=K 0x5C, SE=K 0xFD, FS=K 0xFE, FE=K 0xF7. A BS state has type 0000 and an SR state has type 0101 (bits 5:2). Each is followed by one VBID state (0010), one MVID state (0011) and one MAUD state (0100). Dummy states (0110) follow until an SS or a BS/SR/BE. A BE state has type 0001 and starts active video.
- R4: After an SS in dummy fill, the next state names the packet. A second SS gives MSA (0111) when the vertical flag is 1 and reserved (1010) otherwise. A data byte 0x01 gives audio timestamp (1001), 0x02 gives audio stream (1000), 0x04 gives extension (1011), 0x80 to 0x8F gives info frame (1100), and any other byte gives reserved (1010). That type holds on every state up to and including the SE. The SS state itself shows dummy.
- R5: In video, data states show pixel type 0001. The states from an FS through the matching FE, both included, show filler type 0010.
- R6: `pkt_seen` is 1 for exactly the one state in which a packet type is identified (the state after the opening SS).
- R7: Bit 0 (mismatch) is set when any active lane differs from lane 0 in its K flag or its byte. This check applies on every state where an active lane carries a K symbol, and on the VBID, MVID and MAUD states.
- R8: `lane_count` 0 means lane 0 is active, 1 means lanes 0 to 1 are active, and 2 or 3 means lanes 0 to 3 are active. Inactive lanes are ignored by the mismatch check and by the scrambler-reset watchdog.
- R9: On an MVID state, bit 1 is set when the last VBID had its no-video bit (bit 3) set and the MVID byte is non-zero.
- R10: On a MAUD state, bit 1 is set when the last VBID had its audio-mute bit (bit 4) set and the MAUD byte is non-zero.
- R11: On a BE state, bit 1 (missed reset) is set when that BE is the 512th one counted on an active lane since the last SR on any active lane or since the last missed-reset report. Counting then starts again from zero.
- R12: The error bits apply to one state only and are not held. `data_error` is 1 exactly when bit 1 or bit 0 of the code is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock; one state per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_count | input | 2 | Active lanes: 0 means one lane, 1 means two lanes, 2 or 3 means four lanes |
| lane_is_k | input | LANES | Per-lane control-symbol flag |
| lane_byte | input | LANES*8 | Per-lane decoded byte, lane n in bits 8n+7:8n |
| event_code | output | 8 | Registered event code for the previous state |
| data_error | output | 1 | The state carried at least one error flag |
| pkt_seen | output | 1 | One-clock pulse when a secondary packet type is identified |

## Verification
If the stream-position state goes wrong, the code shows it one clock later. A lost VBID/MVID/MAUD step puts the wrong type on the states after BS. A stale region bit puts a pixel or dummy code in the wrong place. A packet type that is not latched shows as dummy inside the packet. Faults in the watchdog counters are the slowest to surface: a counter that resets too early or too late shows only at the 512th BE, or as a flag after an SR should have cleared it. For that reason the bench drives long BE runs, both with and without an intervening SR.

// File: rtl/dpev_pkg.sv
// Shared constants, phase encoding and helper functions for the stream
// event classifier. Assumes symbols are already decoded and descrambled.
package dpev_pkg;

    // Control symbol byte values (K flag set)
    localparam logic [7:0] SYM_BS = 8'hBC;
    localparam logic [7:0] SYM_SR = 8'h1C;
    localparam logic [7:0] SYM_BE = 8'hFB;
    localparam logic [7:0] SYM_SS = 8'h5C;
    localparam logic [7:0] SYM_SE = 8'hFD;
    localparam logic [7:0] SYM_FS = 8'hFE;
    localparam logic [7:0] SYM_FE = 8'hF7;

    // Type field (code bits 5:2)
    localparam logic [3:0] T_BS    = 4'b0000;
    localparam logic [3:0] T_BE    = 4'b0001;
    localparam logic [3:0] T_VBID  = 4'b0010;
    localparam logic [3:0] T_MVID  = 4'b0011;
    localparam logic [3:0] T_MAUD  = 4'b0100;
    localparam logic [3:0] T_SR    = 4'b0101;
    localparam logic [3:0] T_DUMMY = 4'b0110;
    localparam logic [3:0] T_MSA   = 4'b0111;
    localparam logic [3:0] T_AUD   = 4'b1000;
    localparam logic [3:0] T_ATS   = 4'b1001;
    localparam logic [3:0] T_RSVD  = 4'b1010;
    localparam logic [3:0] T_EXT   = 4'b1011;
    localparam logic [3:0] T_INFO  = 4'b1100;
    localparam logic [3:0] T_PIX   = 4'b0001;
    localparam logic [3:0] T_FILL  = 4'b0010;

    // Position in the stream
    typedef enum logic [2:0] {
        PH_VBID,
        PH_MVID,
        PH_MAUD,
        PH_DUMMY,
        PH_HDR,
        PH_PKT,
        PH_VIDEO
    } phase_t;

    // Number of active lanes for a lane_count setting
    function automatic int act_lanes(input logic [1:0] lc);
        case (lc)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction

    // Packet type named by the header byte following SS
    function automatic logic [3:0] hdr_type(input logic [7:0] b);
        if (b == 8'h01)           return T_ATS;
        else if (b == 8'h02)      return T_AUD;
        else if (b == 8'h04)      return T_EXT;
        else if (b[7:4] == 4'h8)  return T_INFO;
        else                      return T_RSVD;
    endfunction

endpackage

// File: rtl/dpev_lane_cmp.sv
// Cross-lane agreement check. Compares every active lane against lane 0
// on K flag and byte; the result counts only when a K symbol is present
// on an active lane or the caller marks an attribute-field state.
module dpev_lane_cmp
    import dpev_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [1:0]         lane_count,
    input  logic [LANES-1:0]   lane_is_k,
    input  logic [LANES*8-1:0] lane_byte,
    input  logic               chk_data,
    output logic               mismatch
);

    logic any_k;
    logic diff;
    int   act;

    // Compare active lanes with the reference lane
    always_comb begin
        act   = act_lanes(lane_count);
        any_k = lane_is_k[0];
        diff  = 1'b0;
        for (int i = 1; i < LANES; i++) begin
            if (i < act) begin
                any_k = any_k | lane_is_k[i];
                if ((lane_is_k[i] != lane_is_k[0]) ||
                    (lane_byte[i*8 +: 8] != lane_byte[7:0]))
                    diff = 1'b1;
            end
        end
        mismatch = (chk_data || any_k) && diff;
    end

endmodule

// File: rtl/dpev_sr_watch.sv
// Scrambler-reset watchdog. One BE counter per lane; any SR on an active
// lane clears all counters. A lane reaching BE_LIMIT BEs raises 'missed'
// for that state and all counters restart. Inactive lanes stay at zero.
module dpev_sr_watch
    import dpev_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int BE_LIMIT = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         lane_count,
    input  logic [LANES-1:0]   lane_is_k,
    input  logic [LANES*8-1:0] lane_byte,
    output logic               missed
);

    localparam int             CW   = $clog2(BE_LIMIT);
    localparam logic [CW-1:0]  LAST = CW'(BE_LIMIT - 1);

    logic [LANES-1:0] act_v;
    logic [LANES-1:0] be_v;
    logic [LANES-1:0] sr_v;
    logic [LANES-1:0] hit_v;
    logic             sr_any;

    assign sr_any = |sr_v;
    assign missed = |hit_v;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CW-1:0] cnt;

        assign act_v[g] = (g < act_lanes(lane_count));
        assign be_v[g]  = act_v[g] && lane_is_k[g] && (lane_byte[g*8 +: 8] == SYM_BE);
        assign sr_v[g]  = act_v[g] && lane_is_k[g] && (lane_byte[g*8 +: 8] == SYM_SR);
        assign hit_v[g] = be_v[g] && (cnt == LAST);

        // Count BEs since the last reset event on this lane
        always_ff @(posedge clk) begin
            if (!rst_n || sr_any || missed || !act_v[g])
                cnt <= '0;
            else if (be_v[g])
                cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dp_event_classifier.sv
// Stream event classifier. Tracks the stream position from lane 0
// (blanking attributes, dummy fill, secondary packets, active video),
// builds the 8-bit event code and registers it with the error and
// packet pulse outputs. Assumes aligned, descrambled, decoded lanes.
module dp_event_classifier
    import dpev_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int BE_LIMIT = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         lane_count,
    input  logic [LANES-1:0]   lane_is_k,
    input  logic [LANES*8-1:0] lane_byte,
    output logic [7:0]         event_code,
    output logic               data_error,
    output logic               pkt_seen
);

    logic [7:0] d0;
    logic       k0;
    logic       is_bs, is_sr, is_be, is_ss, is_se, is_fs, is_fe;

    phase_t     phase_q, phase_d;
    logic       vert_q, vert_d, field_q, field_d;
    logic       novid_q, novid_d, mute_q, mute_d;
    logic       fill_q, fill_d;
    logic [3:0] ptype_q, ptype_d;

    logic [3:0] typ;
    logic       video, e1, pulse, chk_data;
    logic       mm, missed;
    logic [7:0] code_d;

    assign d0    = lane_byte[7:0];
    assign k0    = lane_is_k[0];
    assign is_bs = k0 && (d0 == SYM_BS);
    assign is_sr = k0 && (d0 == SYM_SR);
    assign is_be = k0 && (d0 == SYM_BE);
    assign is_ss = k0 && (d0 == SYM_SS);
    assign is_se = k0 && (d0 == SYM_SE);
    assign is_fs = k0 && (d0 == SYM_FS);
    assign is_fe = k0 && (d0 == SYM_FE);

    dpev_lane_cmp #(.LANES(LANES)) i_cmp (
        .lane_count (lane_count),
        .lane_is_k  (lane_is_k),
        .lane_byte  (lane_byte),
        .chk_data   (chk_data),
        .mismatch   (mm)
    );

    dpev_sr_watch #(.LANES(LANES), .BE_LIMIT(BE_LIMIT)) i_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_count (lane_count),
        .lane_is_k  (lane_is_k),
        .lane_byte  (lane_byte),
        .missed     (missed)
    );

    // Classify the current state and compute the next stream position
    always_comb begin
        phase_d  = phase_q;
        vert_d   = vert_q;
        field_d  = field_q;
        novid_d  = novid_q;
        mute_d   = mute_q;
        fill_d   = fill_q;
        ptype_d  = ptype_q;
        typ      = T_DUMMY;
        video    = 1'b0;
        e1       = 1'b0;
        pulse    = 1'b0;
        chk_data = 1'b0;
        if (is_sr) begin
            typ     = T_SR;
            phase_d = PH_VBID;
        end else if (is_bs) begin
            typ     = T_BS;
            phase_d = PH_VBID;
        end else if (is_be) begin
            typ     = T_BE;
            e1      = missed;
            phase_d = PH_VIDEO;
            fill_d  = 1'b0;
        end else begin
            case (phase_q)
                PH_VIDEO: begin
                    video = 1'b1;
                    typ   = (fill_q || is_fs) ? T_FILL : T_PIX;
                    if (is_fs) fill_d = 1'b1;
                    if (is_fe) fill_d = 1'b0;
                end
                PH_VBID: begin
                    chk_data = 1'b1;
                    typ      = T_VBID;
                    vert_d   = d0[0];
                    field_d  = d0[1];
                    novid_d  = d0[3];
                    mute_d   = d0[4];
                    phase_d  = PH_MVID;
                end
                PH_MVID: begin
                    chk_data = 1'b1;
                    typ      = T_MVID;
                    e1       = novid_q && (d0 != 8'h00);
                    phase_d  = PH_MAUD;
                end
                PH_MAUD: begin
                    chk_data = 1'b1;
                    typ      = T_MAUD;
                    e1       = mute_q && (d0 != 8'h00);
                    phase_d  = PH_DUMMY;
                end
                PH_DUMMY: begin
                    typ = T_DUMMY;
                    if (is_ss) phase_d = PH_HDR;
                end
                PH_HDR: begin
                    pulse   = 1'b1;
                    phase_d = PH_PKT;
                    if (is_ss) typ = vert_q ? T_MSA : T_RSVD;
                    else       typ = hdr_type(d0);
                    ptype_d = typ;
                end
                PH_PKT: begin
                    typ = ptype_q;
                    if (is_se) phase_d = PH_DUMMY;
                end
                default: phase_d = PH_DUMMY;
            endcase
        end
        code_d = {video, (video ? field_q : vert_d), typ, e1, mm};
    end

    // Register stream position and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_DUMMY;
            vert_q     <= 1'b0;
            field_q    <= 1'b0;
            novid_q    <= 1'b0;
            mute_q     <= 1'b0;
            fill_q     <= 1'b0;
            ptype_q    <= T_DUMMY;
            event_code <= 8'h00;
            data_error <= 1'b0;
            pkt_seen   <= 1'b0;
        end else begin
            phase_q    <= phase_d;
            vert_q     <= vert_d;
            field_q    <= field_d;
            novid_q    <= novid_d;
            mute_q     <= mute_d;
            fill_q     <= fill_d;
            ptype_q    <= ptype_d;
            event_code <= code_d;
            data_error <= e1 | mm;
            pkt_seen   <= pulse;
        end
    end

endmodule

// File: rtl/dp_event_classifier_chk.sv
// Protocol checker for the event classifier outputs, bound to the top.
module dp_event_classifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] event_code,
    input logic       data_error,
    input logic       pkt_seen
);

    // R1: reset clears all outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (event_code == 8'h00 && !data_error && !pkt_seen));

    // R6: packet pulse lasts one state
    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_seen |=> !pkt_seen);

    // R5: video states carry only pixel or filler types, no attribute error bit
    assert_video_types_R5: assert property (@(posedge clk) disable iff (!rst_n)
        event_code[7] |-> ((event_code[5:2] == 4'b0001 || event_code[5:2] == 4'b0010)
                           && !event_code[1]));

    // R9: an MVID state always follows a VBID state
    assert_mvid_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!event_code[7] && event_code[5:2] == 4'b0011) |->
        (!$past(event_code[7]) && $past(event_code[5:2]) == 4'b0010));

    // R10: a MAUD state always follows an MVID state
    assert_maud_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!event_code[7] && event_code[5:2] == 4'b0100) |->
        (!$past(event_code[7]) && $past(event_code[5:2]) == 4'b0011));

endmodule

bind dp_event_classifier dp_event_classifier_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .event_code (event_code),
    .data_error (data_error),
    .pkt_seen   (pkt_seen)
);

// File: tb/test_dp_event_classifier.sv
// Bench: vector table walk, then directed reset and watchdog tests.
module test_dp_event_classifier;

    localparam int NV = 58;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  lane_count = 2'd2;
    logic [3:0]  lane_is_k = 4'h0;
    logic [31:0] lane_byte = 32'h0;
    logic [7:0]  event_code;
    logic        data_error;
    logic        pkt_seen;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dp_event_classifier i_dp_event_classifier (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_count (lane_count),
        .lane_is_k  (lane_is_k),
        .lane_byte  (lane_byte),
        .event_code (event_code),
        .data_error (data_error),
        .pkt_seen   (pkt_seen)
    );

    // Vector: [51:48] req, [47:46] lane_count, [45:42] K mask, [41:10] bytes,
    //         [9:2] expected code, [1] expected error, [0] expected pulse
    function automatic logic [51:0] vx(input logic [3:0] rq, input logic [1:0] lc,
                                       input logic [3:0] k, input logic [31:0] b,
                                       input logic [7:0] c, input logic e, input logic p);
        return {rq, lc, k, b, c, e, p};
    endfunction

    function automatic logic [51:0] vu(input logic [3:0] rq, input logic k,
                                       input logic [7:0] b, input logic [7:0] c,
                                       input logic e, input logic p);
        return {rq, 2'd2, {4{k}}, {4{b}}, c, e, p};
    endfunction

    localparam logic [51:0] VEC [NV] = '{
        vu(3, 1, 8'h1C, 8'h14, 0, 0),  // R3 SR
        vu(3, 0, 8'h01, 8'h48, 0, 0),  // R3 VBID, vertical set (R2)
        vu(3, 0, 8'h00, 8'h4C, 0, 0),  // R3 MVID
        vu(3, 0, 8'h00, 8'h50, 0, 0),  // R3 MAUD
        vu(3, 0, 8'h00, 8'h58, 0, 0),  // R3 dummy
        vu(4, 1, 8'h5C, 8'h58, 0, 0),  // R4 SS shows dummy
        vu(6, 1, 8'h5C, 8'h5C, 0, 1),  // R6 second SS -> MSA
        vu(4, 0, 8'h55, 8'h5C, 0, 0),  // R4 MSA held
        vu(4, 1, 8'hFD, 8'h5C, 0, 0),  // R4 SE keeps type
        vu(3, 0, 8'h00, 8'h58, 0, 0),  // R3 dummy
        vu(4, 1, 8'h5C, 8'h58, 0, 0),  // R4 SS
        vu(6, 0, 8'h02, 8'h60, 0, 1),  // R6 audio stream
        vu(4, 0, 8'h11, 8'h60, 0, 0),  // R4 held
        vu(4, 1, 8'hFD, 8'h60, 0, 0),  // R4 SE
        vu(3, 1, 8'hBC, 8'h40, 0, 0),  // R3 BS
        vu(2, 0, 8'h1A, 8'h08, 0, 0),  // R2 VBID: horiz, field 1, novid, mute
        vu(9, 0, 8'h05, 8'h0E, 1, 0),  // R9 V err
        vu(12, 0, 8'h00, 8'h10, 0, 0), // R12 error not held
        vu(3, 0, 8'h00, 8'h18, 0, 0),  // R3 dummy
        vu(4, 1, 8'h5C, 8'h18, 0, 0),  // R4 SS
        vu(4, 0, 8'h01, 8'h24, 0, 1),  // R4 audio timestamp
        vu(4, 1, 8'hFD, 8'h24, 0, 0),  // R4 SE
        vu(4, 1, 8'h5C, 8'h18, 0, 0),  // R4 SS
        vu(4, 0, 8'h84, 8'h30, 0, 1),  // R4 info frame
        vu(4, 1, 8'hFD, 8'h30, 0, 0),  // R4 SE
        vu(4, 1, 8'h5C, 8'h18, 0, 0),  // R4 SS
        vu(4, 1, 8'h5C, 8'h28, 0, 1),  // R4 double SS in horizontal -> reserved
        vu(4, 1, 8'hFD, 8'h28, 0, 0),  // R4 SE
        vu(4, 1, 8'h5C, 8'h18, 0, 0),  // R4 SS
        vu(4, 0, 8'h04, 8'h2C, 0, 1),  // R4 extension
        vu(4, 1, 8'hFD, 8'h2C, 0, 0),  // R4 SE
        vu(4, 1, 8'h5C, 8'h18, 0, 0),  // R4 SS
        vu(4, 0, 8'h40, 8'h28, 0, 1),  // R4 unknown header -> reserved
        vu(4, 1, 8'hFD, 8'h28, 0, 0),  // R4 SE
        vu(3, 1, 8'hFB, 8'h04, 0, 0),  // R3 BE
        vu(5, 0, 8'h77, 8'hC4, 0, 0),  // R5 pixel, field 1
        vu(5, 1, 8'hFE, 8'hC8, 0, 0),  // R5 FS filler
        vu(5, 0, 8'h00, 8'hC8, 0, 0),  // R5 filler
        vu(5, 1, 8'hF7, 8'hC8, 0, 0),  // R5 FE filler
        vu(5, 0, 8'h00, 8'hC4, 0, 0),  // R5 pixel again
        vu(2, 1, 8'hBC, 8'h00, 0, 0),  // R2 BS
        vu(2, 0, 8'h00, 8'h08, 0, 0),  // R2 VBID field 0
        vu(9, 0, 8'h00, 8'h0C, 0, 0),  // R9 no V err
        vu(10, 0, 8'h03, 8'h10, 0, 0), // R10 not muted: no A err
        vu(3, 1, 8'hFB, 8'h04, 0, 0),  // R3 BE
        vu(2, 0, 8'h00, 8'h84, 0, 0),  // R2 pixel field 0
        vu(3, 1, 8'hBC, 8'h00, 0, 0),  // R3 BS
        vu(3, 0, 8'h10, 8'h08, 0, 0),  // R3 VBID mute
        vu(9, 0, 8'h07, 8'h0C, 0, 0),  // R9 no novid
        vu(10, 0, 8'h02, 8'h12, 1, 0), // R10 A err
        vu(3, 0, 8'h00, 8'h18, 0, 0),  // R3 dummy
        vx(7, 2'd2, 4'hF, 32'hBCBDBCBC, 8'h01, 1, 0), // R7 K mismatch lane 2
        vx(7, 2'd2, 4'h0, 32'h01000000, 8'h09, 1, 0), // R7 VBID mismatch lane 3
        vx(8, 2'd0, 4'h0, 32'h00000900, 8'h0C, 0, 0), // R8 lane 1 inactive
        vx(8, 2'd0, 4'h0, 32'h55555500, 8'h10, 0, 0), // R8 MAUD one lane
        vx(7, 2'd1, 4'hD, 32'hFBFBFBFB, 8'h05, 1, 0), // R7 K flag differs lane 1
        vx(8, 2'd2, 4'h0, 32'h44332211, 8'h84, 0, 0), // R8 data lanes not compared in video
        vx(8, 2'd0, 4'h3, 32'h0000BCFB, 8'h04, 0, 0)  // R8 inactive K ignored
    };

    task automatic step(input logic [1:0] lc, input logic [3:0] k, input logic [31:0] b);
        lane_count = lc;
        lane_is_k  = k;
        lane_byte  = b;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input int rq, input logic [7:0] c, input logic e, input logic p);
        checks++;
        if (event_code !== c || data_error !== e || pkt_seen !== p) begin
            errors++;
            $display("FAIL R%0d: code=%02h err=%0b pulse=%0b expected code=%02h err=%0b pulse=%0b",
                     rq, event_code, data_error, pkt_seen, c, e, p);
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(1, 8'h00, 0, 0);  // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][47:46], VEC[i][45:42], VEC[i][41:10]);
            check(int'(VEC[i][51:48]), VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R1: reset in the middle of a packet
        step(2'd2, 4'hF, {4{8'h5C}});
        rst_n = 1'b0;
        step(2'd2, 4'h0, {4{8'h02}});
        check(1, 8'h00, 0, 0);
        rst_n = 1'b1;

        // R11: 511 BEs quiet, the 512th flags, counting restarts
        step(2'd2, 4'hF, {4{8'h1C}});
        check(11, 8'h14, 0, 0);
        bad = 0;
        for (int n = 0; n < 511; n++) begin
            step(2'd2, 4'hF, {4{8'hFB}});
            if (event_code !== 8'h04 || data_error !== 1'b0) bad++;
        end
        check(11, (bad == 0) ? event_code : 8'hFF, 0, 0);
        step(2'd2, 4'hF, {4{8'hFB}});
        check(11, 8'h06, 1, 0);
        step(2'd2, 4'hF, {4{8'hFB}});
        check(11, 8'h04, 0, 0);

        // R11: an SR between two runs keeps the flag away
        bad = 0;
        for (int n = 0; n < 300; n++) begin
            step(2'd2, 4'hF, {4{8'hFB}});
            if (data_error !== 1'b0) bad++;
        end
        step(2'd2, 4'hF, {4{8'h1C}});
        for (int n = 0; n < 300; n++) begin
            step(2'd2, 4'hF, {4{8'hFB}});
            if (data_error !== 1'b0) bad++;
        end
        check(11, (bad == 0) ? event_code : 8'hFF, 0, 0);

        // R8: SR on an inactive lane does not clear the counters
        step(2'd0, 4'hF, 32'h1C1C1CFB);
        bad = 0;
        for (int n = 0; n < 210; n++) begin
            step(2'd0, 4'h1, 32'h000000FB);
            if (data_error !== 1'b0) bad++;
        end
        check(8, (bad == 0) ? event_code : 8'hFF, 0, 0);
        step(2'd0, 4'h1, 32'h000000FB);
        check(8, 8'h06, 1, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule